// File: doc/BRIEF.md
# Sixteen-Digit Message Loader Sequencer

This block sits on the host side of a bank of four four-character LED displays and loads a sixteen-character message into them with no help from a processor. A host fills a sixteen-entry character buffer through a simple load port and then pulses `start`. The sequencer first walks every display position from the highest to the lowest and clears its cursor bit. It then walks the positions from lowest to highest and writes one character into each position from the buffer.

A 4-bit position value selects the target of each write. Its two low bits become the digit address shared by all displays. Its two high bits are decoded into one active-high select, one per display. Every write is a framed transaction. First there is one idle cycle with all selects low. Then data, address and select are presented for a programmable setup time. Then the active-low write strobe is held low for a programmable width. After the strobe returns high, everything is held for a programmable hold time. The cursor-enable, blank and clear lines to the displays stay at their inactive high level throughout. A mode input lets the block serve 6-bit character sources: it forces the top code bit to the inverse of the bit below it.

Top module: `msg_loader_seq`

## Requirements
- R1: Each write targets one 4-bit position p. `digit_addr` equals p[1:0], and `disp_sel` has only bit p[3:2] set (select k addresses display k). Outside a write window `disp_sel` is all zero, and `wr_n` is never low while `disp_sel` is zero.
- R2: After `start`, the first 16 writes go to positions 15, 14, … 0 in that order. Each has `cursor_sel_n` = 0 and `disp_data` = 0, so bit 0 (the cursor bit) is cleared.
- R3: The next 16 writes go to positions 0, 1, … 15 in that order. Each has `cursor_sel_n` = 1 and carries the code stored at buffer entry p. The operation then ends after exactly 32 writes.
- R4: With `mode_6bit` = 1, a character write drives bit 6 of `disp_data` as the inverse of bit 5, and bits 5..0 come from the buffer. With `mode_6bit` = 0, all 7 stored bits pass unchanged.
- R5: In each write, `disp_sel` is active with `wr_n` high for exactly SETUP_CYC cycles, then `wr_n` is low for exactly STROBE_CYC cycles, then `wr_n` is high with `disp_sel` still active for exactly HOLD_CYC cycles. At least one cycle with `disp_sel` all zero separates two writes.
- R6: `disp_data`, `digit_addr`, `disp_sel` and `cursor_sel_n` do not change at any point inside a write window.
- R7: `busy` is high from the cycle after an accepted `start` until the operation ends. `done` is high for exactly one cycle after the last character write, and `busy` is low in that cycle. A `start` pulse while busy starts nothing extra.
- R8: After reset: `wr_n` = 1, `disp_sel` = 0, `busy` = 0, `done` = 0 and `cursor_sel_n` = 1. `cursor_en`, `blank_n` and `clear_n` are high at all times.
- R9: A cycle with `ld_en` = 1 stores the 7-bit `ld_code` at buffer entry `ld_addr`. A later character pass writes that value to position `ld_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a cursor-clear pass plus message load |
| mode_6bit | input | 1 | 1: source codes are 6-bit, bit 6 is generated |
| ld_en | input | 1 | Buffer write enable |
| ld_addr | input | 4 | Buffer entry (display position) |
| ld_code | input | 7 | Character code to store |
| disp_data | output | 7 | Data lines to all displays |
| digit_addr | output | 2 | Digit address within a display |
| disp_sel | output | 4 | One active-high select per display |
| cursor_sel_n | output | 1 | 0: write targets cursor memory, 1: character memory |
| wr_n | output | 1 | Active-low write strobe |
| cursor_en | output | 1 | Cursor enable, held high |
| blank_n | output | 1 | Blank control, held high (not blanked) |
| clear_n | output | 1 | Clear control, held high (not clearing) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at completion |

## Verification
A wrong position counter or pass state shows up directly on the ports. A write either lands at the wrong address or display select, or carries the wrong cursor-select level. That is visible at the very write where the state went wrong, within one write window (SETUP_CYC+STROBE_CYC+HOLD_CYC+1 cycles). A fault in the strobe timer shows up as a setup, strobe or hold count that is off, or as a select active with no strobe. A fault in data capture shows up as a value that moves inside a window or does not match the buffer. A bad end condition shows up only at the end of the run: as a write count other than 32, a missing or stretched `done`, or writes that continue after `done`.

// File: rtl/msg_pkg.sv
package msg_pkg;
  typedef enum logic [1:0] {
    PASS_IDLE,
    PASS_CURSOR,
    PASS_TEXT
  } pass_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_GAP,
    PH_SETUP,
    PH_LOW,
    PH_HOLD
  } phase_e;
endpackage

// File: rtl/msg_buffer.sv
module msg_buffer #(
  parameter int DEPTH  = 16,
  parameter int CODE_W = 7,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [CODE_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [CODE_W-1:0] rdata
);
  logic [CODE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pos_decoder.sv
module pos_decoder #(
  parameter int NUM_DISP = 4,
  parameter int DIGITS   = 4,
  localparam int ADDR_W  = $clog2(DIGITS),
  localparam int SEL_W   = $clog2(NUM_DISP),
  localparam int POS_W   = ADDR_W + SEL_W
) (
  input  logic [POS_W-1:0]    pos,
  input  logic                active,
  output logic [ADDR_W-1:0]   addr,
  output logic [NUM_DISP-1:0] sel
);
  assign addr = pos[ADDR_W-1:0];

  for (genvar k = 0; k < NUM_DISP; k++) begin : g_sel
    assign sel[k] = active && (pos[POS_W-1:ADDR_W] == SEL_W'(k));
  end
endmodule

// File: rtl/strobe_timer.sv
module strobe_timer
  import msg_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 2,
  localparam int MAX_A     = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC,
  localparam int MAX_C     = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC,
  localparam int CNT_W     = $clog2(MAX_C + 1)
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   go,
  output phase_e phase,
  output logic   fin,
  output logic   wr_n,
  output logic   window
);
  phase_e            phase_q, phase_nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic              wr_n_q, win_q;

  always_comb begin
    phase_nxt = phase_q;
    cnt_nxt   = cnt_q;
    fin       = 1'b0;
    case (phase_q)
      PH_IDLE: if (go) phase_nxt = PH_GAP;
      PH_GAP: begin
        phase_nxt = PH_SETUP;
        cnt_nxt   = CNT_W'(SETUP_CYC - 1);
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_nxt = PH_LOW;
          cnt_nxt   = CNT_W'(STROBE_CYC - 1);
        end else cnt_nxt = cnt_q - 1'b1;
      end
      PH_LOW: begin
        if (cnt_q == '0) begin
          phase_nxt = PH_HOLD;
          cnt_nxt   = CNT_W'(HOLD_CYC - 1);
        end else cnt_nxt = cnt_q - 1'b1;
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          fin       = 1'b1;
          phase_nxt = go ? PH_GAP : PH_IDLE;
        end else cnt_nxt = cnt_q - 1'b1;
      end
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wr_n_q  <= 1'b1;
      win_q   <= 1'b0;
    end else begin
      phase_q <= phase_nxt;
      cnt_q   <= cnt_nxt;
      wr_n_q  <= (phase_nxt != PH_LOW);
      win_q   <= (phase_nxt == PH_SETUP) || (phase_nxt == PH_LOW) ||
                 (phase_nxt == PH_HOLD);
    end
  end

  assign phase  = phase_q;
  assign wr_n   = wr_n_q;
  assign window = win_q;

  a_r5_strobe_count_bound: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_LOW) |-> (int'(cnt_q) < STROBE_CYC));
  a_r5_setup_before_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n_q) |-> $past(win_q));
  a_r5_hold_after_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n_q) |-> win_q);
endmodule

// File: rtl/msg_loader_seq.sv
module msg_loader_seq
  import msg_pkg::*;
#(
  parameter int NUM_DISP   = 4,
  parameter int DIGITS     = 4,
  parameter int CODE_W     = 7,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 2,
  localparam int MSG_LEN   = NUM_DISP * DIGITS,
  localparam int ADDR_W    = $clog2(DIGITS),
  localparam int POS_W     = $clog2(MSG_LEN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                mode_6bit,
  input  logic                ld_en,
  input  logic [POS_W-1:0]    ld_addr,
  input  logic [CODE_W-1:0]   ld_code,
  output logic [CODE_W-1:0]   disp_data,
  output logic [ADDR_W-1:0]   digit_addr,
  output logic [NUM_DISP-1:0] disp_sel,
  output logic                cursor_sel_n,
  output logic                wr_n,
  output logic                cursor_en,
  output logic                blank_n,
  output logic                clear_n,
  output logic                busy,
  output logic                done
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(MSG_LEN - 1);

  pass_e             pass_q, pass_nxt;
  logic [POS_W-1:0]  pos_q, pos_nxt;
  logic              go, fin, win, done_nxt, done_q;
  phase_e            phase;
  logic [CODE_W-1:0] rd_code, code_fix, data_q;
  logic [POS_W-1:0]  lat_pos_q;
  logic              cu_n_q;

  always_comb begin
    pass_nxt = pass_q;
    pos_nxt  = pos_q;
    go       = 1'b0;
    done_nxt = 1'b0;
    case (pass_q)
      PASS_IDLE: if (start) begin
        pass_nxt = PASS_CURSOR;
        pos_nxt  = LAST_POS;
        go       = 1'b1;
      end
      PASS_CURSOR: if (fin) begin
        go = 1'b1;
        if (pos_q == '0) begin
          pass_nxt = PASS_TEXT;
          pos_nxt  = '0;
        end else pos_nxt = pos_q - 1'b1;
      end
      PASS_TEXT: if (fin) begin
        if (pos_q == LAST_POS) begin
          pass_nxt = PASS_IDLE;
          done_nxt = 1'b1;
        end else begin
          pos_nxt = pos_q + 1'b1;
          go      = 1'b1;
        end
      end
      default: pass_nxt = PASS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_q <= PASS_IDLE;
      pos_q  <= '0;
      done_q <= 1'b0;
    end else begin
      pass_q <= pass_nxt;
      pos_q  <= pos_nxt;
      done_q <= done_nxt;
    end
  end

  msg_buffer #(.DEPTH(MSG_LEN), .CODE_W(CODE_W)) u_buf (
    .clk   (clk),
    .we    (ld_en),
    .waddr (ld_addr),
    .wdata (ld_code),
    .raddr (pos_nxt),
    .rdata (rd_code)
  );

  strobe_timer #(.SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC),
                 .HOLD_CYC(HOLD_CYC)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .go     (go),
    .phase  (phase),
    .fin    (fin),
    .wr_n   (wr_n),
    .window (win)
  );

  always_comb begin
    code_fix = rd_code;
    if (mode_6bit) code_fix[CODE_W-1] = ~rd_code[CODE_W-2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      lat_pos_q <= '0;
      cu_n_q    <= 1'b1;
    end else if (phase == PH_GAP) begin
      data_q    <= (pass_q == PASS_CURSOR) ? '0 : code_fix;
      lat_pos_q <= pos_q;
      cu_n_q    <= (pass_q != PASS_CURSOR);
    end
  end

  pos_decoder #(.NUM_DISP(NUM_DISP), .DIGITS(DIGITS)) u_dec (
    .pos    (lat_pos_q),
    .active (win),
    .addr   (digit_addr),
    .sel    (disp_sel)
  );

  assign disp_data    = data_q;
  assign cursor_sel_n = cu_n_q;
  assign cursor_en    = 1'b1;
  assign blank_n      = 1'b1;
  assign clear_n      = 1'b1;
  assign busy         = (pass_q != PASS_IDLE);
  assign done         = done_q;

  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(disp_sel));
  a_r1_strobe_needs_sel: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> (disp_sel != '0));
  a_r6_window_stable: assert property (@(posedge clk) disable iff (rst)
    ((disp_sel != '0) && ($past(disp_sel) != '0)) |->
      ($stable(disp_data) && $stable(digit_addr) && $stable(cursor_sel_n)));
  a_r2_cursor_data_zero: assert property (@(posedge clk) disable iff (rst)
    ((disp_sel != '0) && !cursor_sel_n) |-> (disp_data == '0));
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/msg_loader_seq_tb.sv
module msg_loader_seq_tb;
  localparam int SETUP = 2;
  localparam int LOWC  = 3;
  localparam int HOLD  = 2;

  logic       clk = 1'b0;
  logic       rst, start, mode_6bit, ld_en;
  logic [3:0] ld_addr;
  logic [6:0] ld_code;
  logic [6:0] disp_data;
  logic [1:0] digit_addr;
  logic [3:0] disp_sel;
  logic       cursor_sel_n, wr_n, cursor_en, blank_n, clear_n, busy, done;

  always #2 clk = ~clk;

  msg_loader_seq #(.SETUP_CYC(SETUP), .STROBE_CYC(LOWC), .HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rst(rst), .start(start), .mode_6bit(mode_6bit),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_code(ld_code),
    .disp_data(disp_data), .digit_addr(digit_addr), .disp_sel(disp_sel),
    .cursor_sel_n(cursor_sel_n), .wr_n(wr_n), .cursor_en(cursor_en),
    .blank_n(blank_n), .clear_n(clear_n), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  logic [6:0] mem [16];

  int         wcount, done_cnt, done_wide, ph, scnt, lcnt, hcnt;
  logic       prev_done, mism;
  logic [3:0] lpos [32];
  logic [6:0] ldata [32];
  logic       lcu [32];
  logic [3:0] r_sel;
  logic [1:0] r_addr;
  logic [6:0] r_data;
  logic       r_cu;

  task automatic chk(input string req, input logic ok, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_code(input logic [6:0] c, input logic m6);
    return m6 ? {~c[5], c[5:0]} : c;
  endfunction

  function automatic int sel_idx(input logic [3:0] s);
    for (int k = 0; k < 4; k++) if (s[k]) return k;
    return 0;
  endfunction

  // Port monitor: frames each write window and measures its timing.
  always @(negedge clk) begin
    if (rst) begin
      ph = 0; prev_done = 1'b0;
    end else begin
      if (done) begin
        done_cnt++;
        if (prev_done) done_wide++;
      end
      prev_done = done;
      if (disp_sel != 4'b0) begin
        if (ph == 0) begin
          ph = 1; scnt = 0; lcnt = 0; hcnt = 0; mism = 1'b0;
          r_sel = disp_sel; r_addr = digit_addr; r_data = disp_data; r_cu = cursor_sel_n;
          chk("R1", $onehot(disp_sel), "select one-hot", int'(disp_sel), 1);
        end else if (disp_sel != r_sel || digit_addr != r_addr ||
                     disp_data != r_data || cursor_sel_n != r_cu) begin
          mism = 1'b1;
        end
        if (!wr_n) begin
          if (ph == 3) chk("R5", 1'b0, "second strobe in window", 2, 1);
          ph = 2; lcnt++;
        end else if (ph == 2) begin
          ph = 3; hcnt = 1;
          if (wcount < 32) begin
            lpos[wcount]  = {2'(sel_idx(r_sel)), r_addr};
            ldata[wcount] = r_data;
            lcu[wcount]   = r_cu;
          end
          wcount++;
        end else if (ph == 3) hcnt++;
        else scnt++;
      end else begin
        if (!wr_n) chk("R1", 1'b0, "strobe without select", 0, 1);
        if (ph != 0) begin
          chk("R5", scnt == SETUP, "setup cycles", scnt, SETUP);
          chk("R5", lcnt == LOWC, "strobe cycles", lcnt, LOWC);
          chk("R5", hcnt == HOLD, "hold cycles", hcnt, HOLD);
          chk("R6", !mism, "window stability", int'(mism), 0);
          ph = 0;
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic load(input logic [3:0] a, input logic [6:0] c);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_code = c;
    mem[a] = c;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_and_check(input logic m6);
    int waited;
    wcount = 0; done_cnt = 0; done_wide = 0;
    @(negedge clk);
    mode_6bit = m6;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7", busy == 1'b1, "busy after start", int'(busy), 1);
    repeat (40) @(negedge clk);
    start = 1'b1;                        // R7: ignored while busy
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    chk("R7", done == 1'b1, "done seen", int'(done), 1);
    chk("R7", busy == 1'b0, "busy low with done", int'(busy), 0);
    chk("R3", wcount == 32, "writes at done", wcount, 32);
    repeat (30) @(negedge clk);
    chk("R7", wcount == 32, "no writes after done", wcount, 32);
    chk("R7", done_cnt == 1, "done pulses", done_cnt, 1);
    chk("R7", done_wide == 0, "done width over one", done_wide, 0);
    for (int i = 0; i < 32 && i < wcount; i++) begin
      if (i < 16) begin
        chk("R2", lpos[i] == 4'(15 - i), "cursor pass position", int'(lpos[i]), 15 - i);
        chk("R2", lcu[i] == 1'b0, "cursor select", int'(lcu[i]), 0);
        chk("R2", ldata[i] == 7'd0, "cursor data", int'(ldata[i]), 0);
      end else begin
        chk("R3", lpos[i] == 4'(i - 16), "text pass position", int'(lpos[i]), i - 16);
        chk("R3", lcu[i] == 1'b1, "text select", int'(lcu[i]), 1);
        chk(m6 ? "R4" : "R9", ldata[i] == exp_code(mem[i - 16], m6), "character",
            int'(ldata[i]), int'(exp_code(mem[i - 16], m6)));
      end
    end
  endtask

  initial begin
    void'($urandom(32'd5150));
    rst = 1'b1; start = 1'b0; mode_6bit = 1'b0;
    ld_en = 1'b0; ld_addr = '0; ld_code = '0;
    wcount = 0; done_cnt = 0; done_wide = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk("R8", wr_n == 1'b1, "wr_n", int'(wr_n), 1);
    chk("R8", disp_sel == 4'b0, "disp_sel", int'(disp_sel), 0);
    chk("R8", busy == 1'b0, "busy", int'(busy), 0);
    chk("R8", done == 1'b0, "done", int'(done), 0);
    chk("R8", cursor_sel_n == 1'b1, "cursor_sel_n", int'(cursor_sel_n), 1);
    chk("R8", {cursor_en, blank_n, clear_n} == 3'b111, "static controls",
        int'({cursor_en, blank_n, clear_n}), 7);

    // Random 7-bit message, full-code mode (R9, R3)
    for (int p = 0; p < 16; p++) load(4'(p), 7'($urandom));
    run_and_check(1'b0);

    // Directed corners: bit 5 set and clear with bit 6 both ways (R4)
    for (int p = 0; p < 16; p++)
      load(4'(p), (p % 4 == 0) ? 7'h7F : (p % 4 == 1) ? 7'h00 :
                  (p % 4 == 2) ? 7'h20 : 7'h5F);
    run_and_check(1'b1);

    // Random again in 6-bit mode, partial reload of the buffer (R9)
    for (int p = 0; p < 16; p += 3) load(4'(p), 7'($urandom));
    run_and_check(1'b1);

    chk("R8", {cursor_en, blank_n, clear_n} == 3'b111, "static controls at end",
        int'({cursor_en, blank_n, clear_n}), 7);
    finish_run();
  end
endmodule